// File: doc/BRIEF.md
# Level-Prioritized Interrupt Controller with Vectoring

This block gathers interrupt request lines from on-chip peripherals and from off-chip pins into one set of sources. Each source carries a programmable priority level from 1 to 7, with level 0 disabling it. A mask bit removes a source from arbitration. The block encodes the highest level that has an unmasked pending source onto an active-low 3-bit priority output toward a 68000-style CPU. Sources that share a level are not ranked by hardware. Software tells them apart by reading the pending word.

When the CPU runs an interrupt-acknowledge bus cycle, the block captures a vector for the acknowledged level and holds it on the data bus until the strobe is released. There is one vector per level: five programmable upper bits joined to the level number. If no unmasked source is pending at that level when the cycle is recognized, a fixed spurious vector is returned instead. The vector path has no back-pressure of its own. The address strobe acts as the ready side: the vector and its acknowledge stay stable for as long as the strobe stays low, and the strobe can be released on any cycle.

A plain synchronous write port and a combinational read port give software access to the pending, mask, type, vector-base and per-source level registers.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `ipl_n` is 3'b111, `vec_oe` is 0, `dtack_n` is 1, the pending word (address 0) reads 0, the mask word (address 1) reads all ones, the type word (address 2) reads 0, the vector base (address 3) reads 0, and every level register reads 0.
- R2: In an edge-type source (type bit = 1 at address 2), a rising input edge sets the pending bit on the next clock. The bit stays set after the input falls, until software writes 1 to that bit at address 0. Writing 0 to the bit leaves it unchanged.
- R3: In a level-type source (type bit = 0), the pending bit equals the input value from one clock earlier. Writes to address 0 have no effect on it.
- R4: A masked source (mask bit = 1 at address 1, bit i = source i) still shows its pending bit at address 0 but does not affect `ipl_n`.
- R5: `ipl_n` is the bitwise inverse of the highest level held by any unmasked pending source. A source with level 0 never raises a request. With no such source, `ipl_n` is 3'b111.
- R6: An acknowledge cycle is recognized when `cpu_fc` is 3'b111 and `cpu_as_n` is 0. On the next clock, `vec_oe` goes to 1 and `dtack_n` goes to 0, and `vec_data` shows {vector base[4:0], acknowledged level from `cpu_addr_lvl`}. These values hold while `cpu_as_n` stays low. They are withdrawn on the clock after the strobe is released.
- R7: Two sources that share a level receive the same vector.
- R8: If the acknowledged level has no unmasked pending source with that level when the cycle is recognized, the captured vector is 8'h18.
- R9: A strobe with any `cpu_fc` other than 3'b111 never drives `vec_oe` or `dtack_n`.
- R10: The registers live at fixed addresses: pending at 0, mask at 1, type at 2, vector base at 3 (bits 4:0), and the level of source i at 16+i (bits 2:0). Other addresses read 0.
- R11: If a rising edge and a software clear reach the same edge-type pending bit in the same clock, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Interrupt request lines, bit i = source i |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 6 | Register address for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| ipl_n | output | 3 | Active-low priority level toward the CPU |
| cpu_fc | input | 3 | CPU function code |
| cpu_as_n | input | 1 | CPU address strobe, active low |
| cpu_addr_lvl | input | 3 | CPU address bits carrying the acknowledged level |
| vec_data | output | 8 | Vector byte, zero when not driven |
| vec_oe | output | 1 | Vector bus drive enable |
| dtack_n | output | 1 | Active-low acknowledge for the vector cycle |

## Verification
Single requests on level-type and edge-type lines separate the two pending behaviours: one source follows its input, the other latches the edge and waits for a clear. Overlapping requests at different levels, and then at the same level, show whether arbitration picks the maximum and whether lines that share a level collapse onto one vector. Masking the top source while it stays asserted, acknowledging an empty level, and strobing with a non-acknowledge function code test the exclusion, spurious and no-drive paths. A long random run of request toggles, mask writes and acknowledge cycles of varied length is compared against a behavioural model on every clock.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int LVL_W      = 3;
  localparam int NUM_LVL    = 1 << LVL_W;
  localparam int VBASE_W    = 8 - LVL_W;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 32;
  localparam logic [ADDR_W-1:0] A_PEND  = 6'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 6'd1;
  localparam logic [ADDR_W-1:0] A_TYPE  = 6'd2;
  localparam logic [ADDR_W-1:0] A_VBASE = 6'd3;
  localparam int A_LVL_BASE = 16;
  localparam logic [2:0] FC_ACK = 3'b111;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] edge_sel,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic hist_q;
    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        hist_q <= irq_in[g];
        if (edge_sel[g]) begin
          // a new edge wins over a clear in the same cycle
          pend_q <= (pend_q & ~clr[g]) | (irq_in[g] & ~hist_q);
        end else begin
          pend_q <= irq_in[g];
        end
      end
    end
    assign pend[g] = pend_q;
  end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel
  import irq_vec_pkg::*;
#(
  parameter int N_SRC = 16
) (
  input  logic [N_SRC-1:0]       pend,
  input  logic [N_SRC-1:0]       mask,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat,
  output lvl_t                   top_lvl,
  output logic [NUM_LVL-1:0]     lvl_act
);
  logic [N_SRC-1:0] live;
  assign live = pend & ~mask;

  always_comb begin
    lvl_act = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (live[i]) lvl_act[lvl_flat[i*LVL_W +: LVL_W]] = 1'b1;
    end
    lvl_act[0] = 1'b0;
  end

  always_comb begin
    top_lvl = '0;
    for (int l = 1; l < NUM_LVL; l++) begin
      if (lvl_act[l]) top_lvl = lvl_t'(l);
    end
  end
endmodule

// File: rtl/irq_iack_unit.sv
module irq_iack_unit
  import irq_vec_pkg::*;
#(
  parameter logic [7:0] SPUR_VEC = 8'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cpu_fc,
  input  logic               cpu_as_n,
  input  lvl_t               ack_lvl,
  input  logic [NUM_LVL-1:0] lvl_act,
  input  logic [VBASE_W-1:0] vbase,
  output logic [7:0]         vec_data,
  output logic               vec_oe,
  output logic               dtack_n
);
  logic       ack_cyc;
  logic       busy_q;
  logic [7:0] vec_q;

  assign ack_cyc = (cpu_fc == FC_ACK) && !cpu_as_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vec_q  <= '0;
    end else if (!busy_q && ack_cyc) begin
      busy_q <= 1'b1;
      vec_q  <= lvl_act[ack_lvl] ? {vbase, ack_lvl} : SPUR_VEC;
    end else if (busy_q && !ack_cyc) begin
      busy_q <= 1'b0;
    end
  end

  assign vec_oe   = busy_q;
  assign dtack_n  = ~busy_q;
  assign vec_data = busy_q ? vec_q : 8'h00;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int         N_SRC    = 16,
  parameter logic [7:0] SPUR_VEC = 8'h18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     irq_in,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic [LVL_W-1:0]     ipl_n,
  input  logic [2:0]           cpu_fc,
  input  logic                 cpu_as_n,
  input  logic [LVL_W-1:0]     cpu_addr_lvl,
  output logic [7:0]           vec_data,
  output logic                 vec_oe,
  output logic                 dtack_n
);
  localparam int FLAT_W = N_SRC * LVL_W;

  logic [N_SRC-1:0]   mask_q;
  logic [N_SRC-1:0]   edge_q;
  logic [VBASE_W-1:0] vbase_q;
  logic [FLAT_W-1:0]  lvl_flat;
  logic [N_SRC-1:0]   clr_vec;
  logic [N_SRC-1:0]   pend;
  lvl_t               top_lvl;
  logic [NUM_LVL-1:0] lvl_act;

  assign clr_vec = (cfg_we && cfg_addr == A_PEND) ? cfg_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      edge_q  <= '0;
      vbase_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_MASK)  mask_q  <= cfg_wdata[N_SRC-1:0];
      if (cfg_addr == A_TYPE)  edge_q  <= cfg_wdata[N_SRC-1:0];
      if (cfg_addr == A_VBASE) vbase_q <= cfg_wdata[VBASE_W-1:0];
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_LVL_BASE + g);
    lvl_t lvl_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else if (cfg_we && cfg_addr == MY_ADDR) lvl_q <= cfg_wdata[LVL_W-1:0];
    end
    assign lvl_flat[g*LVL_W +: LVL_W] = lvl_q;
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_PEND:  cfg_rdata[N_SRC-1:0]   = pend;
      A_MASK:  cfg_rdata[N_SRC-1:0]   = mask_q;
      A_TYPE:  cfg_rdata[N_SRC-1:0]   = edge_q;
      A_VBASE: cfg_rdata[VBASE_W-1:0] = vbase_q;
      default: begin
        for (int i = 0; i < N_SRC; i++) begin
          if (cfg_addr == ADDR_W'(A_LVL_BASE + i))
            cfg_rdata[LVL_W-1:0] = lvl_flat[i*LVL_W +: LVL_W];
        end
      end
    endcase
  end

  irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .edge_sel (edge_q),
    .clr      (clr_vec),
    .pend     (pend)
  );

  irq_level_sel #(.N_SRC(N_SRC)) u_sel (
    .pend     (pend),
    .mask     (mask_q),
    .lvl_flat (lvl_flat),
    .top_lvl  (top_lvl),
    .lvl_act  (lvl_act)
  );

  assign ipl_n = ~top_lvl;

  irq_iack_unit #(.SPUR_VEC(SPUR_VEC)) u_iack (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_fc   (cpu_fc),
    .cpu_as_n (cpu_as_n),
    .ack_lvl  (cpu_addr_lvl),
    .lvl_act  (lvl_act),
    .vbase    (vbase_q),
    .vec_data (vec_data),
    .vec_oe   (vec_oe),
    .dtack_n  (dtack_n)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_vec_pkg::*;
#(
  parameter int         N_SRC    = 16,
  parameter logic [7:0] SPUR_VEC = 8'h18
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_SRC-1:0]   irq_in,
  input logic [N_SRC-1:0]   edge_q,
  input logic [N_SRC-1:0]   clr_vec,
  input logic [N_SRC-1:0]   pend,
  input logic [N_SRC-1:0]   mask_q,
  input logic [LVL_W-1:0]   ipl_n,
  input logic [2:0]         cpu_fc,
  input logic               cpu_as_n,
  input logic [LVL_W-1:0]   cpu_addr_lvl,
  input logic [NUM_LVL-1:0] lvl_act,
  input logic [VBASE_W-1:0] vbase_q,
  input logic [7:0]         vec_data,
  input logic               vec_oe,
  input logic               dtack_n
);
  // R5 / R4: nothing live means no request
  p_idle_ipl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mask_q) == '0) |-> (ipl_n == '1));

  // R2: an edge-type pending bit survives unless cleared
  p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(pend) & $past(edge_q) & ~$past(clr_vec) & ~pend) == '0));

  // R3: a level-type pending bit tracks the input one clock back
  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((pend ^ $past(irq_in)) & ~$past(edge_q)) == '0));

  // R6: captured vector for a live level
  p_vec_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_oe) && $past(lvl_act[cpu_addr_lvl])) |->
      (vec_data == {$past(vbase_q), $past(cpu_addr_lvl)}));

  // R8: empty level yields the spurious vector
  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_oe) && !$past(lvl_act[cpu_addr_lvl])) |-> (vec_data == SPUR_VEC));

  // R6: vector held steady while driven
  p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe && $past(vec_oe)) |-> ($stable(vec_data) && !dtack_n));

  // R9: no drive starts without an acknowledge cycle
  p_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_fc != FC_ACK || cpu_as_n) && !vec_oe) |=> !vec_oe);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_SRC(N_SRC), .SPUR_VEC(SPUR_VEC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_in       (irq_in),
  .edge_q       (edge_q),
  .clr_vec      (clr_vec),
  .pend         (pend),
  .mask_q       (mask_q),
  .ipl_n        (ipl_n),
  .cpu_fc       (cpu_fc),
  .cpu_as_n     (cpu_as_n),
  .cpu_addr_lvl (cpu_addr_lvl),
  .lvl_act      (lvl_act),
  .vbase_q      (vbase_q),
  .vec_data     (vec_data),
  .vec_oe       (vec_oe),
  .dtack_n      (dtack_n)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [2:0]  ipl_n;
  logic [2:0]  cpu_fc = 3'b000;
  logic        cpu_as_n = 1'b1;
  logic [2:0]  cpu_addr_lvl = '0;
  logic [7:0]  vec_data;
  logic        vec_oe;
  logic        dtack_n;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ipl_n(ipl_n), .cpu_fc(cpu_fc), .cpu_as_n(cpu_as_n), .cpu_addr_lvl(cpu_addr_lvl),
    .vec_data(vec_data), .vec_oe(vec_oe), .dtack_n(dtack_n)
  );

  always #5 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model state
  bit [N-1:0] m_pend, m_hist, m_mask, m_edge;
  int         m_lvl [N];
  bit [4:0]   m_vbase;
  bit         m_busy;
  bit [7:0]   m_vec;

  function automatic bit lvl_live(int l);
    if (l == 0) return 0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && !m_mask[i] && m_lvl[i] == l) return 1;
    return 0;
  endfunction

  function automatic int top_live();
    int t = 0;
    for (int l = 1; l < 8; l++) if (lvl_live(l)) t = l;
    return t;
  endfunction

  function automatic bit [31:0] m_read(int a);
    if (a == 0) return 32'(m_pend);
    if (a == 1) return 32'(m_mask);
    if (a == 2) return 32'(m_edge);
    if (a == 3) return 32'(m_vbase);
    if (a >= 16 && a < 16 + N) return 32'(m_lvl[a-16]);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_hist = '0; m_mask = '1; m_edge = '0;
      m_vbase = '0; m_busy = 0; m_vec = '0;
      for (int i = 0; i < N; i++) m_lvl[i] = 0;
    end else begin
      bit ack;
      bit [N-1:0] np;
      ack = (cpu_fc == 3'b111) && !cpu_as_n;
      if (!m_busy && ack) begin
        m_busy = 1;
        m_vec = lvl_live(int'(cpu_addr_lvl)) ? {m_vbase, cpu_addr_lvl} : 8'h18;
      end else if (m_busy && !ack) begin
        m_busy = 0;
      end
      for (int i = 0; i < N; i++) begin
        if (m_edge[i]) begin
          np[i] = m_pend[i];
          if (cfg_we && cfg_addr == 0 && cfg_wdata[i]) np[i] = 0;
          if (irq_in[i] && !m_hist[i]) np[i] = 1;
        end else begin
          np[i] = irq_in[i];
        end
      end
      m_hist = irq_in;
      m_pend = np;
      if (cfg_we) begin
        if (cfg_addr == 1) m_mask = cfg_wdata[N-1:0];
        if (cfg_addr == 2) m_edge = cfg_wdata[N-1:0];
        if (cfg_addr == 3) m_vbase = cfg_wdata[4:0];
        if (cfg_addr >= 16 && cfg_addr < 16 + N) m_lvl[cfg_addr-16] = int'(cfg_wdata[2:0]);
      end
    end
  end

  // compare every clock, late in the low phase
  always @(negedge clk) begin
    #4;
    if (started && !done) begin
      bit [2:0] e_ipl;
      bit [7:0] e_vec;
      bit [31:0] e_rd;
      e_ipl = ~3'(top_live());
      e_vec = m_busy ? m_vec : 8'h00;
      e_rd  = m_read(int'(cfg_addr));
      n_chk++;
      if (ipl_n !== e_ipl || vec_oe !== m_busy || dtack_n !== !m_busy ||
          vec_data !== e_vec || cfg_rdata !== e_rd) begin
        n_bad++;
        $display("FAIL %s t=%0t ipl act=%b exp=%b oe act=%b exp=%b dtack act=%b exp=%b vec act=%h exp=%h rd act=%h exp=%h",
                 cur_req, $time, ipl_n, e_ipl, vec_oe, m_busy, dtack_n, !m_busy,
                 vec_data, e_vec, cfg_rdata, e_rd);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, bit [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = '0;
  endtask

  // directed check with literal expectation, sampled like the model compare
  task automatic direct(string req, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s directed act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic look(int a);
    @(negedge clk);
    cfg_addr = 6'(a);
    #4;
  endtask

  task automatic iack(int lvl, int hold);
    @(negedge clk);
    cpu_fc = 3'b111; cpu_as_n = 0; cpu_addr_lvl = 3'(lvl);
    repeat (hold) @(negedge clk);
    cpu_as_n = 1; cpu_fc = 3'b000;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(posedge clk);
    started = 1;
    step(3);
    rst_n = 1;
    // R1: reset state
    cur_req = "R1";
    look(1); direct("R1", {29'd0, ipl_n}, 32'd7); direct("R1", cfg_rdata, 32'h0000_FFFF);
    direct("R1", {30'd0, vec_oe, dtack_n}, 32'd1);
    look(0); direct("R1", cfg_rdata, 32'd0);
    // R10: configuration and readback
    cur_req = "R10";
    for (int i = 0; i < N; i++) wr(16 + i, (i < 6) ? ((i==0)?1:(i==1)?3:(i==2)?3:(i==3)?5:(i==4)?7:0) : (i % 7) + 1);
    wr(2, 32'h0000_FF00);
    wr(3, 32'hFFFF_FFEA);
    wr(1, 32'h0);
    look(3); direct("R10", cfg_rdata, 32'h0A);
    look(20); direct("R10", cfg_rdata, 32'd7);
    look(40); direct("R10", cfg_rdata, 32'd0);
    // R3: level source follows input
    cur_req = "R3";
    @(negedge clk); irq_in[1] = 1;
    look(0); direct("R3", {29'd0, ipl_n}, 32'(~3'd3 & 3'h7));
    wr(0, 32'h2);
    look(0); direct("R3", cfg_rdata & 32'h2, 32'h2);
    // R5: higher level wins, level 0 ignored
    cur_req = "R5";
    @(negedge clk); irq_in[4] = 1; irq_in[5] = 1;
    look(0); direct("R5", {29'd0, ipl_n}, 32'd0);
    // R4: mask top source
    cur_req = "R4";
    wr(1, 32'h10);
    look(0); direct("R4", {29'd0, ipl_n}, 32'd4); direct("R4", cfg_rdata & 32'h10, 32'h10);
    // R6 / R7: shared level 3 vector
    cur_req = "R6";
    @(negedge clk); irq_in[2] = 1;
    iack(3, 4);
    cur_req = "R7";
    @(negedge clk); irq_in[1] = 0;
    step(1);
    iack(3, 2);
    // R8: spurious for empty level and masked level
    cur_req = "R8";
    iack(6, 2);
    iack(7, 3);
    // R9: other function code
    cur_req = "R9";
    @(negedge clk); cpu_fc = 3'b101; cpu_as_n = 0; cpu_addr_lvl = 3;
    step(3);
    direct("R9", {31'd0, vec_oe}, 32'd0);
    cpu_as_n = 1; cpu_fc = 0;
    // R2: edge source latch and clear
    cur_req = "R2";
    irq_in = '0; wr(1, 32'h0);
    @(negedge clk); irq_in[8] = 1;
    @(negedge clk); irq_in[8] = 0;
    look(0); direct("R2", cfg_rdata & 32'h100, 32'h100);
    wr(0, 32'h0);
    look(0); direct("R2", cfg_rdata & 32'h100, 32'h100);
    wr(0, 32'h100);
    look(0); direct("R2", cfg_rdata & 32'h100, 32'h0);
    // R11: edge and clear in the same clock
    cur_req = "R11";
    @(negedge clk); irq_in[9] = 1;
    @(negedge clk); irq_in[9] = 0;
    @(negedge clk); irq_in[9] = 1; cfg_we = 1; cfg_addr = 0; cfg_wdata = 32'h200;
    @(negedge clk); cfg_we = 0; cfg_wdata = 0;
    look(0); direct("R11", cfg_rdata & 32'h200, 32'h200);
    // random traffic against the model
    cur_req = "R5";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      irq_in = N'($urandom);
      cfg_addr = 6'($urandom_range(0, 40));
      cfg_we = ($urandom_range(0, 15) == 0);
      cfg_wdata = $urandom;
      if (cfg_addr == 2 || cfg_addr == 3) cfg_we = 0;
      cpu_addr_lvl = 3'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        cpu_fc = ($urandom_range(0, 4) == 0) ? 3'b110 : 3'b111;
        cpu_as_n = ~cpu_as_n;
      end
    end
    @(negedge clk); cfg_we = 0; cpu_as_n = 1;
    step(3);
    finish_run();
  end
endmodule